// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Generator

This block derives a serial bit clock from the system clock for a synchronous serial port. The clock passes through two dividers in turn: an even prescaler and then a rate divider. A full bit clock period is `P × (1 + R)` system clocks, where `P` is the even prescale value (2 to 254) and `R` is the rate value (0 to 255). The fastest setting is the system clock divided by 2 and the slowest is the system clock divided by 65024.

The shifter beside this block takes two single-cycle strobes. The lead strobe marks each move of the bit clock away from its idle level. The trail strobe marks each return to the idle level. The shifter uses these strobes to sample and shift data. Frame counting and the data path are outside this block.

While run is low, the bit clock sits at the idle polarity and both counters are cleared. The divider settings are captured only in that state, so changing them during a transfer has no effect.

Top module: `bitclk_gen`

## Requirements
- R1: While running, the bit clock toggles every `(P/2) × (1 + R)` system clocks, so a full period is exactly `P × (1 + R)` clocks, for odd as well as even `1 + R`.
- R2: Bit 0 of the prescale input is ignored: an odd value acts as the even value below it. A prescale value of 0 or 1 acts as 2.
- R3: Every rate value from 0 to 255 is honoured. This includes the extremes: prescale 2 with rate 0 toggles every clock, and prescale 254 with rate 255 toggles every 32512 clocks.
- R4: When run is sampled low at a clock edge, after that edge the bit clock equals the polarity input sampled at that edge, and both strobes are low.
- R5: The lead strobe is high in exactly the cycles in which the bit clock has just moved away from the idle polarity. The trail strobe is high in exactly the cycles in which it has just returned to the idle polarity. The two strobes are never high together, and neither is high in a cycle without a bit clock change.
- R6: Prescale, rate and polarity are captured only at edges where run is low. Changes to them while run stays high do not alter the running bit clock.
- R7: Let run be high for the first time at clock edge E1. The first bit clock change is then visible after edge E(P/2 × (1 + R)).
- R8: Dropping run in the middle of a half period returns the bit clock to idle after the next edge, with no strobe. A later run starts again from cleared counters and uses the R7 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to generate the bit clock; low holds it idle and captures settings |
| cpol_i | input | 1 | Idle level of the bit clock |
| psc_i | input | PSC_W | Prescale value (bit 0 ignored, 0 treated as 2) |
| rate_i | input | RATE_W | Rate value; the divider counts 1 + rate_i prescaler ticks |
| sclk_o | output | 1 | Bit clock |
| lead_o | output | 1 | One-cycle strobe: the bit clock has just left the idle level |
| trail_o | output | 1 | One-cycle strobe: the bit clock has just returned to the idle level |

## Verification
The embedded properties check the following on every cycle:
- the strobes are exclusive and each one coincides with an actual bit clock change;
- the clock returns to the idle level and the strobes are silent one edge after run is low;
- the captured settings hold steady while running;
- the prescaler and rate counters stay below their terminal values.

The exact number of clocks between changes cannot be covered by those properties, and neither can the first-edge latency or the mapping of odd and zero prescale values. The same holds for the claim that settings changed during a run are ignored. The directed scenarios measure these against the formula, including the extremes of both ranges and an abort followed by a restart.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  localparam int unsigned DEF_PSC_W  = 8;
  localparam int unsigned DEF_RATE_W = 8;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'b00,
    EDGE_LEAD  = 2'b01,
    EDGE_TRAIL = 2'b10
  } edge_e;
endpackage

// File: rtl/bitclk_cfg.sv
module bitclk_cfg #(
  parameter int unsigned PSC_W  = bitclk_pkg::DEF_PSC_W,
  parameter int unsigned RATE_W = bitclk_pkg::DEF_RATE_W,
  localparam int unsigned HALF_W = PSC_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [HALF_W-1:0] half_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              cpol_o
);
  logic [HALF_W-1:0] half_in;
  logic [HALF_W-1:0] half_q;
  logic [RATE_W-1:0] rate_q;
  logic              cpol_q;

  // prescale P maps to a half-step count P/2; P below 2 acts as 2
  always_comb begin
    half_in = psc_i[PSC_W-1:1];
    if (half_in == '0) half_in = HALF_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(1);
      rate_q <= '0;
      cpol_q <= 1'b0;
    end else if (!run_i) begin
      half_q <= half_in;
      rate_q <= rate_i;
      cpol_q <= cpol_i;
    end
  end

  assign half_o = half_q;
  assign rate_o = rate_q;
  assign cpol_o = cpol_q;

  // R2
  half_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0);

  // R6
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(half_q) && $stable(rate_q) && $stable(cpol_q)));
endmodule

// File: rtl/bitclk_psc.sv
module bitclk_psc #(
  parameter int unsigned HALF_W = bitclk_pkg::DEF_PSC_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              tick;

  assign tick = run_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + HALF_W'(1);
  end

  assign tick_o = tick;

  // R1
  psc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_i);

  // R8
  psc_idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/bitclk_rate.sv
module bitclk_rate #(
  parameter int unsigned RATE_W = bitclk_pkg::DEF_RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_run_i,
  input  logic              cpol_idle_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  import bitclk_pkg::*;

  logic [RATE_W-1:0] cnt_q;
  logic              flip;
  logic              sclk_q;
  edge_e             edge_d, edge_q;

  assign flip = tick_i && (cnt_q == rate_i);

  always_comb begin
    edge_d = EDGE_NONE;
    if (run_i && flip) edge_d = (sclk_q == cpol_run_i) ? EDGE_LEAD : EDGE_TRAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      edge_q <= EDGE_NONE;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= cpol_idle_i;
      edge_q <= EDGE_NONE;
    end else begin
      edge_q <= edge_d;
      if (tick_i) cnt_q <= flip ? '0 : cnt_q + RATE_W'(1);
      if (flip)   sclk_q <= ~sclk_q;
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = (edge_q == EDGE_LEAD);
  assign trail_o = (edge_q == EDGE_TRAIL);

  // R1
  rate_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= rate_i);
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
  parameter int unsigned PSC_W  = bitclk_pkg::DEF_PSC_W,
  parameter int unsigned RATE_W = bitclk_pkg::DEF_RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  localparam int unsigned HALF_W = PSC_W - 1;

  logic [HALF_W-1:0] half;
  logic [RATE_W-1:0] rate;
  logic              cpol_q;
  logic              tick;

  bitclk_cfg #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .cpol_i (cpol_i),
    .psc_i  (psc_i),
    .rate_i (rate_i),
    .half_o (half),
    .rate_o (rate),
    .cpol_o (cpol_q)
  );

  bitclk_psc #(.HALF_W(HALF_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .half_i (half),
    .tick_o (tick)
  );

  bitclk_rate #(.RATE_W(RATE_W)) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .tick_i      (tick),
    .rate_i      (rate),
    .cpol_run_i  (cpol_q),
    .cpol_idle_i (cpol_i),
    .sclk_o      (sclk_o),
    .lead_o      (lead_o),
    .trail_o     (trail_o)
  );

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_o, trail_o}));

  // R5
  strobe_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o)));

  // R5
  lead_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != cpol_q));

  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sclk_o == $past(cpol_i) && !lead_o && !trail_o));
endmodule

// File: tb/bitclk_gen_bench.sv
module bitclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] psc = 8'd2;
  logic [7:0] rate = 8'd0;
  logic       sclk, lead, trail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  bitclk_gen u_bitclk_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .run_i   (run),
    .cpol_i  (cpol),
    .psc_i   (psc),
    .rate_i  (rate),
    .sclk_o  (sclk),
    .lead_o  (lead),
    .trail_o (trail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Program while idle, run, measure ntog bit clock changes.
  task automatic run_case(input int p, input int r, input bit pol, input int ntog,
                          input bit chg, input string req);
    int h, half, cnt;
    logic prev;
    bit quiet;
    h = p / 2;
    if (h == 0) h = 1;
    half = h * (r + 1);
    @(negedge clk);
    psc = 8'(p); rate = 8'(r); cpol = pol;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == pol, "R4", sclk, pol);
    run = 1'b1;
    prev = sclk;
    for (int t = 0; t < ntog; t++) begin
      cnt = 0;
      quiet = 1'b1;
      do begin
        @(negedge clk);
        cnt++;
        if (sclk == prev && (lead || trail)) quiet = 1'b0;
      end while (sclk == prev && cnt <= half + 2);
      chk(cnt == half, req, cnt, half);
      chk(quiet, "R5", 0, 1);
      chk(lead == (sclk != pol), "R5", lead, sclk != pol);
      chk(trail == (sclk == pol), "R5", trail, sclk == pol);
      prev = sclk;
      if (chg && t == 0) begin
        // R6: new settings while running must not matter
        psc = 8'(p + 20); rate = 8'(r + 5); cpol = ~pol;
      end
    end
    run = 1'b0;
    @(negedge clk);
    chk(sclk == cpol, "R4", sclk, cpol);
    chk(!lead && !trail, "R4", {lead, trail}, 0);
  endtask

  task automatic test_reset();
    chk(sclk == 1'b0 && !lead && !trail, "R4", {sclk, lead, trail}, 0);
  endtask

  task automatic test_idle_follow();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cpol = i[0];
      @(negedge clk);
      chk(sclk == cpol, "R4", sclk, cpol);
      chk(!lead && !trail, "R4", {lead, trail}, 0);
    end
  endtask

  task automatic test_abort();
    int cnt;
    @(negedge clk);
    psc = 8'd8; rate = 8'd2; cpol = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 15; i++) @(negedge clk);
    chk(sclk == 1'b1, "R8", sclk, 1);
    run = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R8", sclk, 0);
    chk(!lead && !trail, "R8", {lead, trail}, 0);
    run = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (sclk == 1'b0 && cnt < 20);
    chk(cnt == 12, "R8", cnt, 12);
    chk(lead, "R8", lead, 1);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_follow();
    run_case(2, 0, 1'b0, 4, 1'b0, "R3");    // fastest
    run_case(0, 0, 1'b0, 3, 1'b0, "R2");    // zero acts as 2
    run_case(7, 1, 1'b1, 3, 1'b0, "R2");    // odd acts as 6
    run_case(4, 3, 1'b0, 4, 1'b0, "R1");
    run_case(6, 4, 1'b1, 4, 1'b0, "R1");    // odd count 5
    run_case(10, 2, 1'b0, 2, 1'b0, "R7");
    run_case(4, 1, 1'b0, 4, 1'b1, "R6");
    test_abort();
    run_case(254, 255, 1'b0, 2, 1'b0, "R3"); // slowest
    finish_run();
  end

  initial begin
    wait (cycles >= 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end
endmodule